// File: doc/BRIEF.md
# Two-Wire Bus Byte-Addressed Memory Target

The block is a 256-byte memory that sits as a target on an open-drain two-wire serial bus (I2C/SMBus style). It watches SCL and SDA through a two-flop synchroniser. It finds START and STOP conditions and compares the 7-bit address that follows a START with its own address. It acknowledges only its own address and pulls SDA low through an output-enable. The address is a fixed base of 0x50 plus an instance index from 0 to 7, so up to eight copies can share one bus.

A write transaction sets the byte pointer from its first data byte. Each later byte is stored at the pointer, and the pointer then steps forward. A read transaction sends the byte at the pointer and steps the pointer forward. It keeps sending while the controller acknowledges each byte. Both directions wrap from 255 to 0.

A separate load port fills a shadow image. The image is copied into the working array only on reset. After reset the array is restored from the image over 256 cycles, and the pointer starts at zero. A sticky flag reports that a data byte has moved in either direction since the last reset.

Top module: `smbus_eeprom`

## Requirements
- R1: The block acknowledges (drives SDA low on the ninth clock) an address byte whose upper seven bits equal 0x50 + INST_IDX, with either R/W bit (bit 0: 0 write, 1 read). It does not acknowledge any other address.
- R2: In a write, the first data byte after the address byte loads the pointer. That byte is not stored in the array.
- R3: Each later byte of a write is stored at the pointer, and the pointer then advances by one modulo 256, so a byte written at 0xFF is followed by one at 0x00.
- R4: A read returns the byte at the pointer, MSB first, and then advances the pointer with wrap from 255 to 0. The block continues with the next byte after a controller ACK. It releases SDA after a NACK.
- R5: Reset clears the pointer to 0 and restores the whole working array from the image. Bytes written over the bus before the reset are lost.
- R6: The accessed flag reads 0 after reset, including after an unacknowledged address. It goes to 1 after the first data byte read or written, and stays at 1 until the next reset.
- R7: A START received while a transaction is in progress (a repeated START) returns the block to address matching. A STOP returns it to idle with SDA released.
- R8: Every byte written to the block, including the pointer byte, is acknowledged.
- R9: Writes through the image load port change only the image. The working array does not see them until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| img_we_i | input | 1 | Image load write strobe |
| img_addr_i | input | 8 | Image load byte address |
| img_data_i | input | 8 | Image load byte value |
| accessed_o | output | 1 | Sticky flag: data moved since reset |

## Verification
The cases that are hardest to reach from the pins are the pointer wrapping in each direction and a pointer byte that must not be stored. To reach them, the bench writes at 0xFE so the data crosses 0xFF, and then sets the pointer alone to 0xFF and reads across the boundary. It also loads the pointer with a write that has no data, then issues a repeated START and reads from the old pointer location. The reload path is checked by changing the image through the load port after the array was written: a read shows the old bus data, and a second reset shows the new image value.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          img_we_i,
  input  logic [AW-1:0] img_addr_i,
  input  logic [7:0]    img_data_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);
  logic [7:0] img_q [DEPTH];
  logic [7:0] arr_q [DEPTH];
  logic [AW:0] rcnt_q;

  assign busy_o = ~rcnt_q[AW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rcnt_q <= '0;
    else if (busy_o) rcnt_q <= rcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (img_we_i) img_q[img_addr_i] <= img_data_i;
  end

  // restore walk owns the array until it completes
  always_ff @(posedge clk_i) begin
    if (busy_o)       arr_q[rcnt_q[AW-1:0]] <= img_q[rcnt_q[AW-1:0]];
    else if (wr_en_i) arr_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = arr_q[rd_addr_i];
endmodule

// File: rtl/smbus_eeprom.sv
module smbus_eeprom
  import smbus_eeprom_pkg::*;
#(
  parameter int unsigned INST_IDX  = 0,
  parameter logic [6:0]  BASE_ADDR = 7'h50,
  parameter int unsigned AW        = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          img_we_i,
  input  logic [AW-1:0] img_addr_i,
  input  logic [7:0]    img_data_i,
  output logic          accessed_o
);
  localparam logic [6:0] DEV_ADDR = BASE_ADDR + 7'(INST_IDX);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;
  logic [7:0] rd_data;

  bus_st_e         state_q;
  logic [3:0]      cnt_q;
  logic [7:0]      shreg_q, txreg_q;
  logic [AW-1:0]   ptr_q;
  logic            rw_q, first_q, more_q;
  logic            rd_load, wr_en, byte_end;

  eeprom_bus_sync u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  eeprom_store #(.AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .img_we_i  (img_we_i),
    .img_addr_i(img_addr_i),
    .img_data_i(img_data_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (ptr_q),
    .wr_data_i (shreg_q),
    .rd_addr_i (ptr_q),
    .rd_data_o (rd_data),
    .busy_o    (busy)
  );

  assign byte_end = scl_fall & (cnt_q == 4'd8) & ~start_det & ~stop_det;
  assign wr_en    = (state_q == ST_WR) & byte_end & ~first_q;
  assign rd_load  = scl_fall & ~start_det & ~stop_det &
                    (((state_q == ST_ADDR_ACK) & rw_q) | ((state_q == ST_RD_ACK) & more_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      more_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      accessed_o <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else if (rd_load) begin
      txreg_q    <= rd_data;
      sda_oe_o   <= ~rd_data[7];
      ptr_q      <= ptr_q + 1'b1;
      cnt_q      <= 4'd1;
      accessed_o <= 1'b1;
      state_q    <= ST_RD;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise && cnt_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_end) begin
            if (shreg_q[7:1] == DEV_ADDR && !busy) begin
              sda_oe_o <= 1'b1;
              rw_q     <= shreg_q[0];
              first_q  <= 1'b1;
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin  // read case handled by rd_load
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WR;
          end
        end
        ST_WR: begin
          if (scl_rise && cnt_q != 4'd8) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (byte_end) begin
            sda_oe_o   <= 1'b1;
            accessed_o <= 1'b1;
            state_q    <= ST_WR_ACK;
            first_q    <= 1'b0;
            if (first_q) ptr_q <= shreg_q[AW-1:0];
            else         ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            state_q  <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q != 4'd8) begin
              sda_oe_o <= ~txreg_q[6];
              txreg_q  <= {txreg_q[6:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RD_ACK;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) more_q <= ~sda_s;
          else if (scl_fall) state_q <= ST_IDLE;  // NACK: ACK path is rd_load
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smbus_eeprom_chk.sv
module smbus_eeprom_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_i,
  input logic [AW-1:0] ptr_i,
  input logic          accessed_i,
  input logic          sda_oe_i,
  input logic          idle_i,
  input logic          rd_load_i
);
  assert_accessed_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accessed_i |=> accessed_i);

  assert_no_access_restore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !accessed_i);

  assert_restore_ptr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ptr_i == '0);

  assert_read_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> ptr_i == AW'($past(ptr_i) + 1'b1));

  assert_idle_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_i);
endmodule

bind smbus_eeprom smbus_eeprom_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .ptr_i     (ptr_q),
  .accessed_i(accessed_o),
  .sda_oe_i  (sda_oe_o),
  .idle_i    (state_q == smbus_eeprom_pkg::ST_IDLE),
  .rd_load_i (rd_load)
);

// File: tb/sim_smbus_eeprom.sv
module sim_smbus_eeprom;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int IDX = 3;
  localparam logic [6:0] MY_ADDR = 7'h50 + 7'(IDX);

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe, accessed;
  logic img_we = 1'b0;
  logic [7:0] img_addr = '0, img_data = '0;
  logic sda_line;
  assign sda_line = ~(sda_oe | m_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_eeprom #(.INST_IDX(IDX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .img_we_i(img_we), .img_addr_i(img_addr),
    .img_data_i(img_data), .accessed_o(accessed)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] img_m [256];
  logic [7:0] mem_m [256];
  logic [7:0] ptr_m = '0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];
  logic [7:0] got_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare each received byte against the scoreboard
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g;
      exp_t e;
      g = got_q.pop_front();
      if (exp_q.size() == 0) check(1'b0, "scoreboard underrun", g, 0);
      else begin
        e = exp_q.pop_front();
        check(g == e.v, e.tag, g, e.v);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(2*Q);
    m_low = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1; tick(2*Q);
    m_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl = 1'b1; tick(2*Q);
      scl = 1'b0; tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q);
      scl = 1'b0; tick(Q);
    end
    m_low = give_ack; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
    m_low = 1'b0;
  endtask

  // write: pointer byte then data; model update; every ACK checked
  task automatic do_write(input logic [7:0] p, input logic [7:0] d[$], input bit stop);
    bit ack;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    check(ack, "R1 own address write ack", ack, 1);
    send_byte(p, ack);
    check(ack, "R8 pointer byte ack", ack, 1);
    ptr_m = p;
    foreach (d[k]) begin
      send_byte(d[k], ack);
      check(ack, "R8 data byte ack", ack, 1);
      mem_m[ptr_m] = d[k];
      ptr_m = ptr_m + 8'd1;
    end
    if (stop) bus_stop();
  endtask

  // read n bytes at model pointer; last one NACKed
  task automatic do_read(input int n, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    check(ack, "R1 own address read ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back('{mem_m[ptr_m], tag});
      ptr_m = ptr_m + 8'd1;
      recv_byte(k < n - 1, b);
      got_q.push_back(b);
    end
    tick(3);
    check(sda_oe == 1'b0, "R4 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(300);
    for (int i = 0; i < 256; i++) mem_m[i] = img_m[i];
    ptr_m = '0;
  endtask

  initial begin
    bit ack;
    logic [7:0] q[$];
    for (int i = 0; i < 256; i++) begin
      img_m[i] = 8'(i * 37 + 11);
      img_we = 1'b1; img_addr = 8'(i); img_data = img_m[i];
      tick(1);
    end
    img_we = 1'b0;
    tick(2);
    check(sda_oe == 1'b0, "R5 reset SDA released", sda_oe, 0);
    check(accessed == 1'b0, "R6 reset accessed clear", accessed, 0);
    do_reset();

    // R1: foreign address not acknowledged, R6 flag unaffected
    bus_start();
    send_byte({7'h50, 1'b0}, ack);
    check(!ack, "R1 foreign address nack", ack, 0);
    bus_stop();
    check(accessed == 1'b0, "R6 no access after nack", accessed, 0);

    // R5 reset pointer 0, restored image
    do_read(3, "R5 read from restored image at pointer 0");
    tick(2);
    check(accessed == 1'b1, "R6 accessed after read", accessed, 1);

    q = '{8'h11, 8'h22, 8'h33};
    do_write(8'h10, q, 1'b1);

    // R2/R7: pointer-only write, repeated START into read at old pointer location 3
    q = '{};
    do_write(8'h03, q, 1'b0);
    do_read(2, "R2 R7 pointer byte not stored, repeated start read");

    q = '{};
    do_write(8'h0F, q, 1'b1);
    do_read(5, "R3 stored bytes at pointer");

    // R3 write wrap across 0xFF
    q = '{8'hA1, 8'hB2, 8'hC3};
    do_write(8'hFE, q, 1'b1);
    q = '{};
    do_write(8'hFE, q, 1'b1);
    do_read(3, "R3 write wrap 0xFF to 0x00");
    // R4 read wrap
    q = '{};
    do_write(8'hFF, q, 1'b1);
    do_read(2, "R4 read wrap 0xFF to 0x00");

    // R9 image port change invisible until reset
    img_we = 1'b1; img_addr = 8'h10; img_data = 8'h5A; tick(1);
    img_we = 1'b0; img_m[8'h10] = 8'h5A;
    q = '{};
    do_write(8'h10, q, 1'b1);
    do_read(1, "R9 image load does not touch array");

    // R5 reset restores image, drops bus writes
    do_reset();
    check(accessed == 1'b0, "R6 accessed cleared by reset", accessed, 0);
    do_read(1, "R5 pointer zero after reset");
    q = '{};
    do_write(8'h10, q, 1'b1);
    do_read(1, "R5 R9 new image value after reset");
    q = '{};
    do_write(8'hFE, q, 1'b1);
    do_read(2, "R5 bus-written bytes reverted");

    tick(20);
    check(exp_q.size() == 0, "R4 all expected bytes received", exp_q.size(), 0);
    summary();
  end
endmodule